// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets synchronous logic use an external 8K x 8 asynchronous static RAM. On the internal side, a client raises a one-cycle request with a write flag, a 13-bit address and, for writes, a data byte. The controller then produces the memory strobes with a fixed, parameter-derived number of wait cycles per phase. It raises a one-cycle completion pulse when the access is over. For reads, that pulse comes with the captured byte.

The memory side has an address bus, a shared data bus split into input, output and output-enable, two chip selects of opposite polarity, an active-low output enable and an active-low write enable. Each memory timing limit is given in nanoseconds. It becomes a cycle count by dividing by the clock period and rounding up, with a floor of one cycle. A slower speed grade or a faster clock therefore needs only new parameter values.

Top module: `async_sram_ctl`

## Requirements
- R1: While the chip is selected, `mem_addr_o` holds the address that was accepted with the request, and it does not change until the chip is deselected.
- R2: Outside an access, the chip is deselected (`mem_ce1_n_o`=1, `mem_ce2_o`=0) with `mem_oe_n_o`=1, `mem_we_n_o`=1 and `mem_dq_oe_o`=0. During an access, `mem_ce1_n_o`=0 and `mem_ce2_o`=1. The same idle values apply after reset.
- R3: A read (`wr_i`=0) starts in the cycle after acceptance. It selects the chip with `mem_oe_n_o`=0 and `mem_we_n_o`=1 for RD cycles. RD is the largest of the rounded-up address access time, cycle time and output-enable access time.
- R4: A write (`wr_i`=1) starts with one setup cycle: chip selected, `mem_we_n_o`=1. Then come WP cycles with `mem_we_n_o`=0, then one hold cycle with `mem_we_n_o`=1 and the chip still selected. WP is the larger of the rounded-up write pulse width and data setup time. `mem_oe_n_o` stays 1 for the whole write.
- R5: The data driver `mem_dq_oe_o` is 1 exactly in the cycles where `mem_we_n_o` is 0. In those cycles, `mem_dq_o` carries the accepted write byte.
- R6: The byte on `mem_dq_i` in the last read cycle is registered. It appears on `rdata_o` in the following cycle, and `rdata_o` changes in no other cycle.
- R7: `done_o` is high for exactly one cycle. That cycle immediately follows the last read cycle or the write hold cycle, and in it all strobes are back at their idle values.
- R8: A write that follows a read gets TURN extra cycles after acceptance with all strobes idle, before its setup cycle. TURN is the rounded-up bus release time. A write after a write, and a read after anything, get no extra cycles.
- R9: A request raised while an access is in progress has no effect. The running access completes unchanged and no further access is started.
- R10: Each wait count is the timing limit in nanoseconds times 1000, divided by `CLK_PS` and rounded up, and never less than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request, sampled only while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write byte |
| rdata_o | output | DATA_W | Last read byte |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | ADDR_W | Memory address pins |
| mem_dq_i | input | DATA_W | Data bus as seen from the memory |
| mem_dq_o | output | DATA_W | Data bus value driven by the controller |
| mem_dq_oe_o | output | 1 | Controller data driver enable |
| mem_ce1_n_o | output | 1 | Active-low chip select |
| mem_ce2_o | output | 1 | Active-high chip select |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_we_n_o | output | 1 | Active-low write enable |

## Verification
Several properties are checked on every cycle. The data driver must track the write strobe, and output enable must be high while writing. Strobes may be active only while the chip is selected. The address must hold while selected, and the driver must never turn on in the cycle after output enable was low. Completion must be single-cycle and idle, and read data may change only with completion. Phase lengths, the extra turnaround cycles that depend on the previous access type, byte-exact data paths through a memory model, and ignored requests during a busy access are shown only by the bench scenarios. There, a cycle-accurate model runs with slowed timing parameters, so that multi-cycle phases and rounding take effect.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_TURN,
      ST_WSETUP,
      ST_WPULSE,
      ST_WHOLD
   } asram_state_e;

   // nanosecond limit -> whole clock cycles, rounded up, at least one (R10)
   function automatic int unsigned ns_to_cycles(int unsigned lim_ns, int unsigned clk_ps);
      int unsigned c;
      c = (lim_ns * 1000 + clk_ps - 1) / clk_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
   parameter int unsigned CNT_W    = 1,
   parameter int unsigned MAX_LOAD = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last_o
);
   generate
      if (MAX_LOAD == 0) begin : g_single
         // every phase is one cycle long: no counter needed
         logic unused_timer;
         assign unused_timer = ^{clk, rst_n, load, load_val};
         assign last_o       = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)               cnt_q <= '0;
            else if (load)            cnt_q <= load_val;
            else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
         end
         assign last_o = (cnt_q == '0);
      end
   endgenerate
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
   import asram_pkg::*;
#(
   parameter int unsigned CNT_W     = 1,
   parameter int unsigned RD_LOAD   = 0,
   parameter int unsigned WP_LOAD   = 0,
   parameter int unsigned TURN_LOAD = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             wr,
   input  logic             last,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             accept,
   output logic             capture,
   output logic             sel_o,
   output logic             oe_n_o,
   output logic             we_n_o,
   output logic             dq_oe_o,
   output logic             done_o
);
   asram_state_e state_q, state_d;
   logic         after_read_q;
   logic         done_d;

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = '0;
      accept   = 1'b0;
      capture  = 1'b0;
      done_d   = 1'b0;
      case (state_q)
         ST_IDLE: if (req) begin
            accept = 1'b1;
            load   = 1'b1;
            if (!wr) begin
               state_d  = ST_READ;
               load_val = CNT_W'(RD_LOAD);
            end else if (after_read_q) begin
               state_d  = ST_TURN;
               load_val = CNT_W'(TURN_LOAD);
            end else begin
               state_d  = ST_WSETUP;
            end
         end
         ST_READ: if (last) begin
            state_d = ST_IDLE;
            capture = 1'b1;
            done_d  = 1'b1;
         end
         ST_TURN: if (last) begin
            state_d = ST_WSETUP;
            load    = 1'b1;
         end
         ST_WSETUP: if (last) begin
            state_d  = ST_WPULSE;
            load     = 1'b1;
            load_val = CNT_W'(WP_LOAD);
         end
         ST_WPULSE: if (last) begin
            state_d = ST_WHOLD;
            load    = 1'b1;
         end
         ST_WHOLD: if (last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // strobes registered from the next state so they change cleanly with it
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         after_read_q <= 1'b0;
         sel_o        <= 1'b0;
         oe_n_o       <= 1'b1;
         we_n_o       <= 1'b1;
         dq_oe_o      <= 1'b0;
         done_o       <= 1'b0;
      end else begin
         state_q <= state_d;
         if (capture)                          after_read_q <= 1'b1;
         else if (state_q == ST_WHOLD && last) after_read_q <= 1'b0;
         sel_o   <= (state_d inside {ST_READ, ST_WSETUP, ST_WPULSE, ST_WHOLD});
         oe_n_o  <= (state_d != ST_READ);
         we_n_o  <= (state_d != ST_WPULSE);
         dq_oe_o <= (state_d == ST_WPULSE);
         done_o  <= done_d;
      end
   end
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic [DATA_W-1:0] rdata_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_addr_o <= '0;
         mem_dq_o   <= '0;
         rdata_o    <= '0;
      end else begin
         if (accept) begin
            mem_addr_o <= addr_i;
            mem_dq_o   <= wdata_i;
         end
         if (capture) rdata_o <= mem_dq_i;
      end
   end
endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W        = 13,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PS        = 20000,
   parameter int unsigned T_CYCLE_NS    = 12,
   parameter int unsigned T_ADDR_ACC_NS = 12,
   parameter int unsigned T_OE_ACC_NS   = 6,
   parameter int unsigned T_WE_PULSE_NS = 10,
   parameter int unsigned T_DATA_SU_NS  = 6,
   parameter int unsigned T_BUS_REL_NS  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe_o,
   output logic              mem_ce1_n_o,
   output logic              mem_ce2_o,
   output logic              mem_oe_n_o,
   output logic              mem_we_n_o
);
   localparam int unsigned RD_CYC = max3(ns_to_cycles(T_ADDR_ACC_NS, CLK_PS),
                                         ns_to_cycles(T_CYCLE_NS, CLK_PS),
                                         ns_to_cycles(T_OE_ACC_NS, CLK_PS));
   localparam int unsigned WP_CYC = max3(ns_to_cycles(T_WE_PULSE_NS, CLK_PS),
                                         ns_to_cycles(T_DATA_SU_NS, CLK_PS), 1);
   localparam int unsigned TURN_CYC = ns_to_cycles(T_BUS_REL_NS, CLK_PS);
   localparam int unsigned MAX_LOAD = max3(RD_CYC, WP_CYC, TURN_CYC) - 1;
   localparam int unsigned CNT_W    = (MAX_LOAD > 0) ? $clog2(MAX_LOAD + 1) : 1;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("async_sram_ctl: address and data widths must be nonzero");
      end
      if (CLK_PS == 0) begin : g_bad_clk
         $error("async_sram_ctl: clock period must be nonzero");
      end
   endgenerate

   logic             load, last, accept, capture, sel;
   logic [CNT_W-1:0] load_val;

   asram_phase_timer #(.CNT_W(CNT_W), .MAX_LOAD(MAX_LOAD)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .last_o(last)
   );

   asram_fsm #(
      .CNT_W(CNT_W), .RD_LOAD(RD_CYC - 1), .WP_LOAD(WP_CYC - 1), .TURN_LOAD(TURN_CYC - 1)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req(req_i), .wr(wr_i), .last(last),
      .load(load), .load_val(load_val), .accept(accept), .capture(capture),
      .sel_o(sel), .oe_n_o(mem_oe_n_o), .we_n_o(mem_we_n_o),
      .dq_oe_o(mem_dq_oe_o), .done_o(done_o)
   );

   asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
      .addr_i(addr_i), .wdata_i(wdata_i), .mem_dq_i(mem_dq_i),
      .mem_addr_o(mem_addr_o), .mem_dq_o(mem_dq_o), .rdata_o(rdata_o)
   );

   assign mem_ce1_n_o = ~sel;
   assign mem_ce2_o   = sel;
endmodule

// File: rtl/async_sram_ctl_chk.sv
module async_sram_ctl_chk #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done_o,
   input logic [DATA_W-1:0] rdata_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_dq_oe_o,
   input logic              mem_ce1_n_o,
   input logic              mem_ce2_o,
   input logic              mem_oe_n_o,
   input logic              mem_we_n_o
);
   p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce1_n_o && $past(!mem_ce1_n_o)) |-> $stable(mem_addr_o));

   p_strobe_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n_o || !mem_we_n_o) |-> (!mem_ce1_n_o && mem_ce2_o));

   p_oe_high_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n_o |-> mem_oe_n_o);

   p_drv_with_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe_o == !mem_we_n_o);

   p_rdata_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata_o) |-> done_o);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (mem_ce1_n_o && !mem_ce2_o && mem_oe_n_o && mem_we_n_o));

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!mem_oe_n_o) |-> !mem_dq_oe_o);
endmodule

bind async_sram_ctl async_sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .done_o(done_o), .rdata_o(rdata_o),
   .mem_addr_o(mem_addr_o), .mem_dq_oe_o(mem_dq_oe_o), .mem_ce1_n_o(mem_ce1_n_o),
   .mem_ce2_o(mem_ce2_o), .mem_oe_n_o(mem_oe_n_o), .mem_we_n_o(mem_we_n_o)
);

// File: tb/async_sram_ctl_tb_top.sv
module async_sram_ctl_tb_top;
   // slowed timing limits so phases span several cycles at 20 ns
   localparam int CLK_PS   = 20000;
   localparam int T_CYC    = 12;
   localparam int T_AA     = 45;
   localparam int T_OEA    = 6;
   localparam int T_WP     = 30;
   localparam int T_DS     = 50;
   localparam int T_REL    = 25;

   function automatic int cyc(int ns);
      int c;
      c = (ns * 1000) / CLK_PS;
      if (c * CLK_PS < ns * 1000) c++;
      if (c < 1) c = 1;
      return c;
   endfunction
   function automatic int mx(int a, int b);
      return (a > b) ? a : b;
   endfunction

   int rd_n, wp_n, turn_n;

   logic clk = 0, rst_n = 0;
   logic req_i = 0, wr_i = 0;
   logic [12:0] addr_i = '0;
   logic [7:0]  wdata_i = '0;
   logic [7:0]  rdata_o, mem_dq_i, mem_dq_o;
   logic [12:0] mem_addr_o;
   logic done_o, mem_dq_oe_o, mem_ce1_n_o, mem_ce2_o, mem_oe_n_o, mem_we_n_o;

   always #10 clk = ~clk;

   async_sram_ctl #(
      .ADDR_W(13), .DATA_W(8), .CLK_PS(CLK_PS), .T_CYCLE_NS(T_CYC),
      .T_ADDR_ACC_NS(T_AA), .T_OE_ACC_NS(T_OEA), .T_WE_PULSE_NS(T_WP),
      .T_DATA_SU_NS(T_DS), .T_BUS_REL_NS(T_REL)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o), .mem_addr_o(mem_addr_o),
      .mem_dq_i(mem_dq_i), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
      .mem_ce1_n_o(mem_ce1_n_o), .mem_ce2_o(mem_ce2_o), .mem_oe_n_o(mem_oe_n_o),
      .mem_we_n_o(mem_we_n_o)
   );

   // behavioural memory
   logic [7:0] mem_model [int];
   always @(*) begin
      mem_dq_i = 8'h00;
      if (!mem_ce1_n_o && mem_ce2_o && !mem_oe_n_o && mem_we_n_o &&
          mem_model.exists(int'(mem_addr_o)))
         mem_dq_i = mem_model[int'(mem_addr_o)];
   end
   always @(posedge clk)
      if (!mem_ce1_n_o && mem_ce2_o && !mem_we_n_o)
         mem_model[int'(mem_addr_o)] = mem_dq_o;

   // cycle-by-cycle reference
   typedef struct {
      bit sel; bit oe_n; bit we_n; bit drv; bit done; bit chk_rd;
      logic [7:0] rd; logic [12:0] addr; logic [7:0] wd;
   } exp_t;
   exp_t q[$];
   logic [7:0] shadow [int];
   bit last_rd = 0;
   bit chk_en = 0;
   bit finished = 0;
   int checks = 0, errors = 0;

   function automatic exp_t idle_e();
      exp_t e;
      e = '{sel:0, oe_n:1, we_n:1, drv:0, done:0, chk_rd:0, rd:0, addr:0, wd:0};
      return e;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) if (chk_en) begin
      exp_t e;
      e = (q.size() > 0) ? q.pop_front() : idle_e();
      chk(mem_ce1_n_o == !e.sel && mem_ce2_o == e.sel, "R2 chip selects",
          {mem_ce1_n_o, mem_ce2_o}, {!e.sel, e.sel});
      chk(mem_oe_n_o == e.oe_n, "R3 output enable", mem_oe_n_o, e.oe_n);
      chk(mem_we_n_o == e.we_n, "R4 write enable", mem_we_n_o, e.we_n);
      chk(mem_dq_oe_o == e.drv, "R5 driver enable", mem_dq_oe_o, e.drv);
      chk(done_o == e.done, "R7 done pulse", done_o, e.done);
      if (e.sel) chk(mem_addr_o == e.addr, "R1 address", mem_addr_o, e.addr);
      if (e.drv) chk(mem_dq_o == e.wd, "R5 write data", mem_dq_o, e.wd);
      if (e.chk_rd) chk(rdata_o == e.rd, "R6 read data", rdata_o, e.rd);
   end

   // R9: intrude raises a foreign request during the busy access
   task automatic op(bit wr, logic [12:0] a, logic [7:0] d, bit intrude);
      exp_t e;
      @(posedge clk); #2;
      req_i = 1; wr_i = wr; addr_i = a; wdata_i = d;
      q.push_back(idle_e());
      if (!wr) begin
         for (int i = 0; i < rd_n; i++) begin
            e = idle_e(); e.sel = 1; e.oe_n = 0; e.addr = a; q.push_back(e);
         end
         e = idle_e(); e.done = 1; e.chk_rd = 1;
         e.rd = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
         q.push_back(e);
         last_rd = 1;
      end else begin
         if (last_rd)  // R8
            for (int i = 0; i < turn_n; i++) q.push_back(idle_e());
         e = idle_e(); e.sel = 1; e.addr = a; q.push_back(e);
         for (int i = 0; i < wp_n; i++) begin
            e = idle_e(); e.sel = 1; e.we_n = 0; e.drv = 1; e.addr = a; e.wd = d;
            q.push_back(e);
         end
         e = idle_e(); e.sel = 1; e.addr = a; q.push_back(e);
         e = idle_e(); e.done = 1; q.push_back(e);
         shadow[int'(a)] = d;
         last_rd = 0;
      end
      @(posedge clk); #2;
      req_i = 0;
      if (intrude) begin
         req_i = 1; wr_i = ~wr; addr_i = ~a; wdata_i = ~d;
         @(posedge clk); #2;
         req_i = 0;
      end
      while (q.size() > 0) @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      rd_n   = mx(mx(cyc(T_AA), cyc(T_CYC)), cyc(T_OEA));  // R10: 3
      wp_n   = mx(cyc(T_WP), cyc(T_DS));                   // R10: 3
      turn_n = cyc(T_REL);                                 // R10: 2
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      chk_en = 1;                       // R2 reset state checked from here
      repeat (3) @(posedge clk);
      op(1, 13'h0001, 8'hA5, 0);        // R4 R5 write, no turnaround
      op(0, 13'h0001, 8'h00, 0);        // R3 R6 read back
      op(1, 13'h1FFF, 8'h3C, 0);        // R8 write after read
      op(1, 13'h0000, 8'hC3, 0);        // R8 write after write, no extra
      op(0, 13'h1FFF, 8'h00, 0);        // R6
      op(0, 13'h0000, 8'h00, 0);        // read after read
      op(0, 13'h0AAA, 8'h00, 0);        // unwritten location
      op(1, 13'h0123, 8'h5A, 1);        // R9 read request during write ignored
      op(0, 13'h0123, 8'h00, 1);        // R9 write request during read ignored
      op(0, 13'h1EDC, 8'h00, 0);        // R9 intruding write left no trace
      for (int i = 0; i < 8; i++)
         op(i[0], 13'(i * 997), 8'(i * 37 + 1), 0);
      repeat (4) @(posedge clk);
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end
endmodule